// File: doc/BRIEF.md
# Event Timer Comparator Channel

This block is one compare channel that sits next to a free-running main counter. It holds a comparator, a hidden period register and a small configuration word. Once armed, it raises an expiry event when the counter reaches the comparator. The compare uses the full counter width, or only its low half when the channel is set to narrow mode. In periodic mode the channel reloads itself: after each expiry it adds the period to the comparator until the comparator is ahead of the count again. In narrow one-shot mode it also fires once when the low half of the counter rolls over past all ones. The real match then follows.

Each expiry drives an interrupt. In level mode it sets a status bit that holds the interrupt high until software clears it. In edge mode the status bit stays low and the interrupt pulses for a single cycle. The counter, address decoding and interrupt routing live outside the block. Software reaches the channel through write strobes for the configuration word and for the low and high comparator halves, plus a status-clear strobe. The current configuration and comparator are visible on the output ports.

Top module: `tick_compare_channel`

## Requirements
- R1: After reset the comparator reads all ones, the hidden period is zero, and the configuration word reads 0x60. That value has bit 5 (periodic capable) and bit 6 (full-width capable) set; both bits are read-only. irq_o, sts_o and expire_o are low.
- R2: An armed, enabled channel fires when the difference comparator minus count, taken as a signed value at the selected width, is zero or negative. expire_o pulses on the clock edge that samples that count. A one-shot channel fires once and then stays quiet.
- R3: If the comparator is already behind the count when the channel is armed, the channel fires on the next count sample after arming, and that expiry is never lost.
- R4: In periodic mode with a non-zero period, each expiry adds the period to the comparator. The channel keeps adding the period, one add per cycle, until the comparator is ahead of the count. This produces exactly one expiry, however far the count has jumped.
- R5: In narrow mode (config bit 4) the periodic sum wraps within the low 32 bits. A period written in narrow mode has bit 31 cleared; a period written in full-width mode has bit 63 cleared.
- R6: A comparator write updates the comparator when the channel is not periodic (config bit 2 clear) or when set-value (config bit 3) is set. In periodic mode the same write also loads the period register.
- R7: The set-value bit clears itself after any comparator write, whether to the low or the high half.
- R8: Writing the configuration with narrow mode set truncates the stored comparator and period to their low 32 bits. In narrow mode, high-half comparator writes are ignored.
- R9: In narrow one-shot mode, an expiry occurs when the low 32 bits of the count reach all ones before the match. The match expiry still follows afterwards.
- R10: In level mode (config bit 0 set) an expiry sets sts_o and holds irq_o high until sts_clr_i is pulsed.
- R11: In edge mode an expiry leaves sts_o low and drives irq_o high for exactly one cycle.
- R12: A falling edge of the channel enable (config bit 1) or of glb_en_i disarms the channel and drops sts_o and irq_o. A rising channel enable, a comparator write while glb_en_i is high, or a rising glb_en_i (when the comparator is not all ones) arms the channel.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rst_n | input | 1 | asynchronous active-low reset |
| count_i | input | CNT_W | main counter value |
| glb_en_i | input | 1 | global enable for counting and interrupts |
| cfg_we_i | input | 1 | configuration write strobe |
| cfg_wdata_i | input | 8 | configuration write data |
| cmp_lo_we_i | input | 1 | low comparator half write strobe |
| cmp_hi_we_i | input | 1 | high comparator half write strobe |
| cmp_wdata_i | input | CNT_W/2 | comparator half write data |
| sts_clr_i | input | 1 | clears the status bit |
| expire_o | output | 1 | one-cycle expiry event |
| irq_o | output | 1 | interrupt request |
| sts_o | output | 1 | interrupt status bit |
| cfg_o | output | 8 | current configuration word |
| cmp_o | output | CNT_W | current comparator |

## Verification
Each strobe changes cfg_o or cmp_o on the edge that samples it. Arming takes one more edge, so the earliest expiry after a write is on the third edge. After that, expire_o, sts_o and irq_o change on the same edge that samples a qualifying count, and an edge-mode pulse falls one edge later. The bench changes inputs only at falling edges and samples 1 ns after rising edges. Each expected expiry is queued under the count value at which it must fire, so a late, early, missing or extra event shows up as a count mismatch or an empty or leftover queue. During catch-up the count is held still, so the final comparator can be predicted exactly.

// File: rtl/tcc_pkg.sv
package tcc_pkg;
  localparam int CFG_W  = 8;
  localparam int B_LVL  = 0;
  localparam int B_EN   = 1;
  localparam int B_PER  = 2;
  localparam int B_SETV = 3;
  localparam int B_M32  = 4;
  localparam int B_PCAP = 5;
  localparam int B_WCAP = 6;

  localparam logic [CFG_W-1:0] CFG_WMASK = 8'h1F;
  localparam logic [CFG_W-1:0] CFG_RST   = (8'h1 << B_PCAP) | (8'h1 << B_WCAP);

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_ARMED = 2'd1,
    ST_CATCH = 2'd2
  } chan_st_e;
endpackage

// File: rtl/tcc_cfg_reg.sv
module tcc_cfg_reg
  import tcc_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we,
  input  logic [CFG_W-1:0] wdata,
  input  logic             setv_clr,
  output logic [CFG_W-1:0] cfg_q,
  output logic             en_rise,
  output logic             en_fall,
  output logic             m32_wr
);
  logic [CFG_W-1:0] nxt;

  always_comb begin
    nxt     = (wdata & CFG_WMASK) | (cfg_q & ~CFG_WMASK);
    en_rise = we & ~cfg_q[B_EN] & wdata[B_EN];
    en_fall = we & cfg_q[B_EN] & ~wdata[B_EN];
    m32_wr  = we & wdata[B_M32];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q <= CFG_RST;
    end else if (we) begin
      cfg_q <= nxt;
    end else if (setv_clr) begin
      cfg_q[B_SETV] <= 1'b0;
    end
  end
endmodule

// File: rtl/tcc_cmp_store.sv
module tcc_cmp_store #(
  parameter int W = 64
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         lo_we,
  input  logic         hi_we,
  input  logic [W/2-1:0] wdata,
  input  logic         periodic,
  input  logic         setv,
  input  logic         m32,
  input  logic         trunc,
  input  logic         adv,
  output logic [W-1:0] cmp_q,
  output logic [W-1:0] per_q
);
  localparam int H = W / 2;

  logic [H-1:0] lo_per_val;
  logic [H-1:0] hi_per_val;
  logic         cmp_sel;
  logic [W-1:0] adv_val;

  always_comb begin
    cmp_sel    = ~periodic | setv;
    lo_per_val = m32 ? {1'b0, wdata[H-2:0]} : wdata;
    hi_per_val = {1'b0, wdata[H-2:0]};
    if (m32) adv_val = {{H{1'b0}}, cmp_q[H-1:0] + per_q[H-1:0]};
    else     adv_val = cmp_q + per_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmp_q <= '1;
      per_q <= '0;
    end else if (trunc) begin
      cmp_q <= {{H{1'b0}}, cmp_q[H-1:0]};
      per_q <= {{H{1'b0}}, per_q[H-1:0]};
    end else if (lo_we) begin
      if (cmp_sel)  cmp_q[H-1:0] <= wdata;
      if (periodic) per_q[H-1:0] <= lo_per_val;
    end else if (hi_we) begin
      if (!m32) begin
        if (cmp_sel)  cmp_q[W-1:H] <= wdata;
        if (periodic) per_q[W-1:H] <= hi_per_val;
      end
    end else if (adv) begin
      cmp_q <= adv_val;
    end
  end
endmodule

// File: rtl/tcc_match.sv
module tcc_match #(
  parameter int W = 64
) (
  input  logic [W-1:0] cmp,
  input  logic [W-1:0] cnt,
  input  logic         m32,
  output logic         due,
  output logic         wrap_hit,
  output logic         wrap_need
);
  localparam int H = W / 2;

  logic [H-1:0] d32;
  logic [H-1:0] d32_eff;
  logic [W-1:0] d64;
  logic         due32;
  logic         due64;

  always_comb begin
    d32       = cmp[H-1:0] - cnt[H-1:0];
    d64       = cmp - cnt;
    due32     = d32[H-1] | (d32 == '0);
    due64     = d64[W-1] | (d64 == '0);
    due       = m32 ? due32 : due64;
    d32_eff   = due32 ? {{(H-1){1'b0}}, 1'b1} : d32;
    wrap_hit  = &cnt[H-1:0];
    wrap_need = (~cnt[H-1:0]) < d32_eff;
  end
endmodule

// File: rtl/tcc_irq_out.sv
module tcc_irq_out (
  input  logic clk,
  input  logic rst_n,
  input  logic fire,
  input  logic level,
  input  logic clr,
  input  logic drop,
  output logic sts_q,
  output logic irq_o
);
  logic pulse_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sts_q   <= 1'b0;
      pulse_q <= 1'b0;
    end else begin
      pulse_q <= fire & ~level & ~drop;
      if (drop)      sts_q <= 1'b0;
      else if (fire) sts_q <= level;
      else if (clr)  sts_q <= 1'b0;
    end
  end

  always_comb irq_o = (sts_q & level) | pulse_q;
endmodule

// File: rtl/tick_compare_channel.sv
module tick_compare_channel
  import tcc_pkg::*;
#(
  parameter int CNT_W = 64
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [CNT_W-1:0]   count_i,
  input  logic               glb_en_i,
  input  logic               cfg_we_i,
  input  logic [7:0]         cfg_wdata_i,
  input  logic               cmp_lo_we_i,
  input  logic               cmp_hi_we_i,
  input  logic [CNT_W/2-1:0] cmp_wdata_i,
  input  logic               sts_clr_i,
  output logic               expire_o,
  output logic               irq_o,
  output logic               sts_o,
  output logic [7:0]         cfg_o,
  output logic [CNT_W-1:0]   cmp_o
);
  logic [CFG_W-1:0] cfg_q;
  logic             en_rise, en_fall, m32_wr;
  logic [CNT_W-1:0] cmp_q, per_q;
  logic             due, wrap_hit, wrap_need;
  logic             glb_q, arm_q, wrap_q, expire_q;
  chan_st_e         st_q;
  logic             glb_rise, glb_fall, cmp_wr, disarm, arm_d;
  logic             live, per_on, fire, adv;

  tcc_cfg_reg u_cfg (
    .clk      (clk),
    .rst_n    (rst_n),
    .we       (cfg_we_i),
    .wdata    (cfg_wdata_i),
    .setv_clr (cmp_wr),
    .cfg_q    (cfg_q),
    .en_rise  (en_rise),
    .en_fall  (en_fall),
    .m32_wr   (m32_wr)
  );

  tcc_cmp_store #(.W(CNT_W)) u_store (
    .clk      (clk),
    .rst_n    (rst_n),
    .lo_we    (cmp_lo_we_i),
    .hi_we    (cmp_hi_we_i),
    .wdata    (cmp_wdata_i),
    .periodic (cfg_q[B_PER]),
    .setv     (cfg_q[B_SETV]),
    .m32      (cfg_q[B_M32]),
    .trunc    (m32_wr),
    .adv      (adv),
    .cmp_q    (cmp_q),
    .per_q    (per_q)
  );

  tcc_match #(.W(CNT_W)) u_match (
    .cmp       (cmp_q),
    .cnt       (count_i),
    .m32       (cfg_q[B_M32]),
    .due       (due),
    .wrap_hit  (wrap_hit),
    .wrap_need (wrap_need)
  );

  tcc_irq_out u_irq (
    .clk   (clk),
    .rst_n (rst_n),
    .fire  (fire),
    .level (cfg_q[B_LVL]),
    .clr   (sts_clr_i),
    .drop  (disarm),
    .sts_q (sts_o),
    .irq_o (irq_o)
  );

  always_comb begin
    glb_rise = glb_en_i & ~glb_q;
    glb_fall = ~glb_en_i & glb_q;
    cmp_wr   = cmp_lo_we_i | cmp_hi_we_i;
    disarm   = en_fall | glb_fall;
    arm_d    = (en_rise | (cmp_wr & glb_en_i) | (glb_rise & ~(&cmp_q))) & ~disarm;
    live     = cfg_q[B_EN] & glb_en_i & ~arm_q & ~disarm;
    per_on   = cfg_q[B_PER] & (|per_q);
    fire     = live & (st_q == ST_ARMED) & (wrap_q ? wrap_hit : due);
    adv      = live & per_on & due &
               (((st_q == ST_ARMED) & ~wrap_q) | (st_q == ST_CATCH));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      glb_q    <= 1'b0;
      arm_q    <= 1'b0;
      wrap_q   <= 1'b0;
      expire_q <= 1'b0;
      st_q     <= ST_IDLE;
    end else begin
      glb_q    <= glb_en_i;
      arm_q    <= arm_d;
      expire_q <= fire;
      if (disarm) begin
        st_q   <= ST_IDLE;
        wrap_q <= 1'b0;
      end else if (arm_q) begin
        st_q   <= ST_ARMED;
        wrap_q <= cfg_q[B_M32] & ~cfg_q[B_PER] & wrap_need;
      end else if (live) begin
        case (st_q)
          ST_ARMED: begin
            if (wrap_q) begin
              if (wrap_hit) wrap_q <= 1'b0;
            end else if (due) begin
              st_q <= per_on ? ST_CATCH : ST_IDLE;
            end
          end
          ST_CATCH: if (!due) st_q <= ST_ARMED;
          default: ;
        endcase
      end
    end
  end

  always_comb begin
    expire_o = expire_q;
    cfg_o    = cfg_q;
    cmp_o    = cmp_q;
  end
endmodule

// File: rtl/tcc_checks.sv
module tcc_checks
  import tcc_pkg::*;
#(
  parameter int CNT_W = 64
) (
  input logic             clk,
  input logic             rst_n,
  input logic             glb_en_i,
  input logic             cfg_we_i,
  input logic             cmp_lo_we_i,
  input logic             sts_clr_i,
  input logic [7:0]       cfg_o,
  input logic [CNT_W-1:0] cmp_o,
  input logic             sts_o,
  input logic             irq_o,
  input logic             expire_o
);
  assert_reset_clean_R1: assert property (@(posedge clk)
    !rst_n |=> (cmp_o == '1 && !sts_o && !irq_o && !expire_o && cfg_o == CFG_RST));

  assert_setv_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (cmp_lo_we_i && !cfg_we_i) |=> !cfg_o[B_SETV]);

  assert_narrow_cmp_R8: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_o[B_M32] |-> (cmp_o[CNT_W-1:CNT_W/2] == '0));

  assert_level_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (sts_o && cfg_o[B_LVL] && !sts_clr_i && !cfg_we_i && glb_en_i) |=> sts_o);

  assert_edge_pulse_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (expire_o && !cfg_o[B_LVL]) |-> (irq_o && !sts_o));

  assert_glb_off_quiet_R12: assert property (@(posedge clk) disable iff (!rst_n)
    !glb_en_i |=> (!sts_o && !irq_o));
endmodule

bind tick_compare_channel tcc_checks #(.CNT_W(CNT_W)) u_tcc_checks (
  .clk         (clk),
  .rst_n       (rst_n),
  .glb_en_i    (glb_en_i),
  .cfg_we_i    (cfg_we_i),
  .cmp_lo_we_i (cmp_lo_we_i),
  .sts_clr_i   (sts_clr_i),
  .cfg_o       (cfg_o),
  .cmp_o       (cmp_o),
  .sts_o       (sts_o),
  .irq_o       (irq_o),
  .expire_o    (expire_o)
);

// File: tb/test_tick_compare_channel.sv
`timescale 1ns/1ps
module test_tick_compare_channel;
  localparam int CW = 64;
  localparam logic [7:0] C_LVL = 8'h01, C_EN = 8'h02, C_PER = 8'h04,
                         C_SETV = 8'h08, C_M32 = 8'h10;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [CW-1:0] count_i = '0;
  logic          glb_en = 1'b0, cfg_we = 1'b0, lo_we = 1'b0, hi_we = 1'b0, sts_clr = 1'b0;
  logic [7:0]    cfg_wd = '0;
  logic [CW/2-1:0] cmp_wd = '0;
  logic          expire, irq, sts;
  logic [7:0]    cfg;
  logic [CW-1:0] cmp;

  int checks = 0;
  int fails = 0;
  bit exp_level = 1'b0;
  bit done = 1'b0;
  logic [CW-1:0] sb_q[$];

  always #2 clk = ~clk;

  tick_compare_channel #(.CNT_W(CW)) i_tick_compare_channel (
    .clk(clk), .rst_n(rst_n), .count_i(count_i), .glb_en_i(glb_en),
    .cfg_we_i(cfg_we), .cfg_wdata_i(cfg_wd), .cmp_lo_we_i(lo_we),
    .cmp_hi_we_i(hi_we), .cmp_wdata_i(cmp_wd), .sts_clr_i(sts_clr),
    .expire_o(expire), .irq_o(irq), .sts_o(sts), .cfg_o(cfg), .cmp_o(cmp)
  );

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wcfg(logic [7:0] v);
    @(negedge clk); cfg_wd = v; cfg_we = 1'b1;
    @(negedge clk); cfg_we = 1'b0;
  endtask

  task automatic wlo(logic [31:0] v);
    @(negedge clk); cmp_wd = v; lo_we = 1'b1;
    @(negedge clk); lo_we = 1'b0;
  endtask

  task automatic whi(logic [31:0] v);
    @(negedge clk); cmp_wd = v; hi_we = 1'b1;
    @(negedge clk); hi_we = 1'b0;
  endtask

  task automatic clr_sts();
    @(negedge clk); sts_clr = 1'b1;
    @(negedge clk); sts_clr = 1'b0;
  endtask

  task automatic step(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); count_i = count_i + 1;
    end
  endtask

  task automatic setcnt(logic [63:0] v);
    @(negedge clk); count_i = v;
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  // scoreboard monitor: each expiry must match the next queued count
  initial begin : monitor
    logic [63:0] e;
    bit prev_edge;
    prev_edge = 1'b0;
    forever begin
      @(posedge clk); #1;
      if (prev_edge && !expire) chk("R11 pulse lasts one cycle", {63'b0, irq}, 64'd0);
      prev_edge = 1'b0;
      if (rst_n && expire) begin
        if (sb_q.size() == 0) begin
          checks++; fails++;
          $display("FAIL R2 unexpected expiry actual=%0h expected=none", count_i);
        end else begin
          e = sb_q.pop_front();
          chk("R2 expiry count", count_i, e);
        end
        chk(exp_level ? "R10 level irq" : "R11 edge irq", {63'b0, irq}, 64'd1);
        chk(exp_level ? "R10 status set" : "R11 status clear", {63'b0, sts}, {63'b0, exp_level});
        prev_edge = !exp_level;
      end
    end
  end

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin : driver
    logic [63:0] base, c;
    idle(3);
    // R1 reset state
    chk("R1 comparator", cmp, '1);
    chk("R1 config", {56'b0, cfg}, 64'h60);
    chk("R1 status", {63'b0, sts}, 64'd0);
    chk("R1 irq", {63'b0, irq}, 64'd0);
    chk("R1 expire", {63'b0, expire}, 64'd0);
    @(negedge clk); rst_n = 1'b1;
    @(negedge clk); glb_en = 1'b1;
    idle(1);

    // R2 one-shot full width, level
    wlo(32'd100); whi(32'd0);
    chk("R6 comparator write", cmp, 64'd100);
    exp_level = 1'b1;
    wcfg(C_EN | C_LVL);
    sb_q.push_back(64'd100);
    step(105);
    chk("R10 status held", {63'b0, sts}, 64'd1);
    chk("R10 irq held", {63'b0, irq}, 64'd1);
    clr_sts();
    chk("R10 status cleared", {63'b0, sts}, 64'd0);
    chk("R10 irq cleared", {63'b0, irq}, 64'd0);
    step(10);

    // R6/R7 periodic full width, edge
    wcfg(C_PER | C_SETV);
    base = count_i + 30;
    wlo(base[31:0]);
    chk("R7 set-value self clear", {63'b0, cfg[3]}, 64'd0);
    chk("R6 set-value loads comparator", cmp, base);
    wlo(32'd10);
    chk("R6 periodic write loads period only", cmp, base);
    exp_level = 1'b0;
    wcfg(C_EN | C_PER);
    sb_q.push_back(base); sb_q.push_back(base + 10); sb_q.push_back(base + 20);
    step(int'(base + 25 - count_i));

    // R4 catch-up after a jump
    sb_q.push_back(base + 55);
    setcnt(base + 55);
    idle(6);
    chk("R4 catch-up comparator", cmp, base + 60);
    sb_q.push_back(base + 60);
    step(7);
    wcfg(8'h00);

    // R8 narrow mode truncation
    whi(32'd5); wlo(32'h200);
    chk("R6 both halves", cmp, 64'h5_0000_0200);
    wcfg(C_M32);
    chk("R8 truncated comparator", cmp, 64'h200);
    whi(32'd7);
    chk("R8 high write ignored", cmp, 64'h200);

    // R5 narrow periodic with clamped period
    wcfg(C_M32 | C_PER | C_SETV);
    c = count_i + 20;
    wlo(c[31:0]);
    wlo(32'hFFFF_FFF0);
    wcfg(C_EN | C_M32 | C_PER);
    sb_q.push_back(c);
    step(22);
    chk("R5 narrow sum with clamped period", cmp, (c + 64'h7FFF_FFF0) & 64'hFFFF_FFFF);
    wcfg(C_M32);

    // R9 narrow one-shot wrap event then match
    setcnt(64'hFFFF_FFF0);
    wlo(32'h10);
    exp_level = 1'b1;
    wcfg(C_EN | C_M32 | C_LVL);
    sb_q.push_back(64'hFFFF_FFFF);
    sb_q.push_back(64'h1_0000_0010);
    step(36);
    chk("R9 both events seen", sb_q.size(), 64'd0);

    // R12 global disable drops the interrupt
    @(negedge clk); glb_en = 1'b0;
    @(negedge clk);
    chk("R12 global off status", {63'b0, sts}, 64'd0);
    chk("R12 global off irq", {63'b0, irq}, 64'd0);

    // R3 arming with the comparator already behind
    wcfg(8'h00);
    @(negedge clk); glb_en = 1'b1;
    wlo(32'd50); whi(32'd0);
    setcnt(64'd200);
    wcfg(C_EN | C_LVL);
    sb_q.push_back(64'd200);
    idle(4);
    chk("R3 late arm fired", {63'b0, sts}, 64'd1);
    wcfg(8'h00);
    chk("R12 channel off status", {63'b0, sts}, 64'd0);
    chk("R12 channel off irq", {63'b0, irq}, 64'd0);
    idle(3);

    chk("R2 no pending expiries", sb_q.size(), 64'd0);
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule